// File: doc/BRIEF.md
# Six-Control-Bit Arithmetic-Logic Unit

This block is the purely combinational arithmetic-logic unit of a small 16-bit accumulator-style processor. It has no opcode table. Six independent control bits shape every operation around one core that either adds or ANDs.

Two bits condition each operand: one forces the operand to zero, and one inverts it bitwise. One bit picks addition or bitwise AND. A last bit can invert the result. Many useful functions come from these bits, such as constants, negation, increment, decrement, subtraction in either direction and bitwise OR.

Two status flags travel with the result to a downstream jump-condition unit. One says the result is zero and one says it is negative. The unit holds no state, so every output follows its inputs in the same cycle.

Top module: `alu6`

## Requirements
- R1: Operands `x`, `y` and output `result` are WIDTH bits wide (default 16), and every output depends only on the present inputs.
- R2: On the x side, zeroing comes before inversion: with `zero_x`=1 and `inv_x`=1 the conditioned x is all ones, with `zero_x`=1 alone it is 0, and with `inv_x`=1 alone it is ~x.
- R3: The y side follows the same rule through `zero_y` and `inv_y`.
- R4: With `add_sel`=1 the core adds the conditioned operands in two's complement, wrapping modulo 2^WIDTH, with no carry or overflow output (0xFFFF+1 gives 0; 0x7FFF+1 gives 0x8000).
- R5: With `add_sel`=0 the core returns the bitwise AND of the conditioned operands.
- R6: With `inv_out`=1 the core result is bitwise inverted before it reaches `result`.
- R7: `is_zero` is 1 exactly when `result` equals 0.
- R8: `is_neg` equals bit WIDTH-1 of `result`. Both flags are taken after the `inv_out` inversion.
- R9: Each control word {zero_x,inv_x,zero_y,inv_y,add_sel,inv_out} below yields the stated function:
  - 101010 → 0
  - 111111 → 1
  - 111010 → -1
  - 001100 → x
  - 110000 → y
  - 001101 → ~x
  - 001111 → -x
  - 011111 → x+1
  - 110010 → y-1
  - 000010 → x+y
  - 010011 → x-y
  - 000111 → y-x
  - 000000 → x&y
  - 010101 → x|y

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | WIDTH | First operand |
| y | input | WIDTH | Second operand |
| zero_x | input | 1 | Replace x by zero |
| inv_x | input | 1 | Invert x after zeroing |
| zero_y | input | 1 | Replace y by zero |
| inv_y | input | 1 | Invert y after zeroing |
| add_sel | input | 1 | 1: add, 0: bitwise AND |
| inv_out | input | 1 | Invert the core result |
| result | output | WIDTH | Final result |
| is_zero | output | 1 | Result equals zero |
| is_neg | output | 1 | Result sign bit |

## Verification
Some checks hold for every input the block sees. On every input change, the assertions check that both flags agree with the result. They also check the fixed outcomes of certain control words, whatever the operands: all ones when both sides are zeroed and inverted, zero for a zeroed AND, all ones for inverted zero-plus-zero, and x passed through when y is zeroed.

Other behaviour depends on operand values and can only be shown by the bench's scenarios. These cover wrap-around at the sign and carry boundaries, the full set of fourteen named functions on random and corner operands, and the order of zeroing and inversion on real data.

// File: rtl/alu6_pkg.sv
// Package: shared types for the six-control-bit ALU.
// Assumes: nothing beyond IEEE 1800-2017.
package alu6_pkg;
    // Core operation selected by the add/AND control bit.
    typedef enum logic {
        OP_AND = 1'b0,
        OP_ADD = 1'b1
    } core_op_e;
endpackage

// File: rtl/alu6_cond.sv
// Module: operand conditioner. Optionally forces the operand to zero, then
// optionally inverts it bitwise.
// Assumes: zeroing takes priority in order (applied first), so both set gives all ones.
module alu6_cond #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opd_in,
    input  logic             force_zero,
    input  logic             invert,
    output logic [WIDTH-1:0] opd_out
);
    logic [WIDTH-1:0] zeroed;

    // Zero stage, then inversion stage.
    always_comb begin
        zeroed  = force_zero ? '0 : opd_in;
        opd_out = invert ? ~zeroed : zeroed;
    end
endmodule

// File: rtl/alu6_core.sv
// Module: core operation. Two's-complement sum (wrapping, carry discarded)
// or bitwise AND of two conditioned operands.
// Assumes: operands are already conditioned.
module alu6_core
    import alu6_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  core_op_e         op,
    output logic [WIDTH-1:0] core_out
);
    // Select sum or AND; the sum is truncated to WIDTH bits.
    always_comb begin
        unique case (op)
            OP_ADD:  core_out = a + b;
            default: core_out = a & b;
        endcase
    end
endmodule

// File: rtl/alu6_post.sv
// Module: output stage. Optional inversion of the core result, then flag
// generation on the final value.
// Assumes: flags describe the value after inversion.
module alu6_post #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] core_in,
    input  logic             invert,
    output logic [WIDTH-1:0] final_out,
    output logic             flag_zero,
    output logic             flag_neg
);
    localparam int MSB = WIDTH - 1;

    // Invert if asked, then derive zero and sign flags.
    always_comb begin
        final_out = invert ? ~core_in : core_in;
        flag_zero = ~|final_out;
        flag_neg  = final_out[MSB];
    end
endmodule

// File: rtl/alu6.sv
// Module: six-control-bit ALU top. Conditions both operands, applies the
// add/AND core, optionally inverts, and reports zero/negative flags.
// Assumes: purely combinational use; no clock or reset inside.
module alu6
    import alu6_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             zero_x,
    input  logic             inv_x,
    input  logic             zero_y,
    input  logic             inv_y,
    input  logic             add_sel,
    input  logic             inv_out,
    output logic [WIDTH-1:0] result,
    output logic             is_zero,
    output logic             is_neg
);
    localparam int NSIDE = 2;

    logic [WIDTH-1:0] raw  [NSIDE];
    logic [WIDTH-1:0] cond [NSIDE];
    logic             zsel [NSIDE];
    logic             isel [NSIDE];
    logic [WIDTH-1:0] core_res;
    core_op_e         op;

    // Gather per-side inputs so one generate loop builds both conditioners.
    always_comb begin
        raw[0]  = x;      raw[1]  = y;
        zsel[0] = zero_x; zsel[1] = zero_y;
        isel[0] = inv_x;  isel[1] = inv_y;
        op      = add_sel ? OP_ADD : OP_AND;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        alu6_cond #(.WIDTH(WIDTH)) u_cond (
            .opd_in    (raw[s]),
            .force_zero(zsel[s]),
            .invert    (isel[s]),
            .opd_out   (cond[s])
        );
    end

    alu6_core #(.WIDTH(WIDTH)) u_core (
        .a       (cond[0]),
        .b       (cond[1]),
        .op      (op),
        .core_out(core_res)
    );

    alu6_post #(.WIDTH(WIDTH)) u_post (
        .core_in  (core_res),
        .invert   (inv_out),
        .final_out(result),
        .flag_zero(is_zero),
        .flag_neg (is_neg)
    );
endmodule

// File: rtl/alu6_check.sv
// Module: assertion checker for alu6, attached by bind. Uses immediate
// assertions because the block has no clock.
// Assumes: inputs are 2-state.
module alu6_check #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             zero_x,
    input logic             inv_x,
    input logic             zero_y,
    input logic             inv_y,
    input logic             add_sel,
    input logic             inv_out,
    input logic [WIDTH-1:0] result,
    input logic             is_zero,
    input logic             is_neg
);
    // Property checks evaluated on every input change.
    always_comb begin
        p_zero_flag_r7: assert (is_zero == (result == '0));
        p_neg_flag_r8:  assert (is_neg == result[WIDTH-1]);
        if (zero_x && inv_x && zero_y && inv_y && !add_sel && !inv_out)
            p_zero_then_inv_r2: assert (result == '1);
        if (zero_x && !inv_x && !add_sel && !inv_out)
            p_and_zero_r5: assert (result == '0);
        if (zero_x && !inv_x && zero_y && !inv_y && add_sel && inv_out)
            p_out_invert_r6: assert (result == '1);
        if (!zero_x && !inv_x && zero_y && !inv_y && add_sel && !inv_out)
            p_add_pass_r4: assert (result == x);
        if (zero_x && !inv_x && !zero_y && !inv_y && add_sel && !inv_out)
            p_y_pass_r3: assert (result == y);
    end
endmodule

bind alu6 alu6_check #(.WIDTH(WIDTH)) u_alu6_check (
    .x(x), .y(y), .zero_x(zero_x), .inv_x(inv_x), .zero_y(zero_y),
    .inv_y(inv_y), .add_sel(add_sel), .inv_out(inv_out),
    .result(result), .is_zero(is_zero), .is_neg(is_neg)
);

// File: tb/alu6_test.sv
// Bench: behavioural reference model compared on every clock.
module alu6_test;
    localparam int W = 16;
    localparam int MASK = 65535;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] x, y;
    logic         zero_x, inv_x, zero_y, inv_y, add_sel, inv_out;
    logic [W-1:0] result;
    logic         is_zero, is_neg;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    always #4 clk = ~clk;

    alu6 #(.WIDTH(W)) uut (
        .x(x), .y(y), .zero_x(zero_x), .inv_x(inv_x), .zero_y(zero_y),
        .inv_y(inv_y), .add_sel(add_sel), .inv_out(inv_out),
        .result(result), .is_zero(is_zero), .is_neg(is_neg)
    );

    // Integer model built from the requirements.
    function automatic int model(int xa, int ya, logic [5:0] c);
        int a, b, r;
        a = c[5] ? 0 : xa;
        if (c[4]) a = a ^ MASK;
        b = c[3] ? 0 : ya;
        if (c[2]) b = b ^ MASK;
        r = c[1] ? ((a + b) & MASK) : (a & b);
        if (c[0]) r = r ^ MASK;
        return r;
    endfunction

    task automatic check(string tag, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Drive one vector at a falling edge, sample 2 ns later, compare all outputs.
    task automatic apply(int xa, int ya, logic [5:0] c, string tag, int exp);
        int r;
        @(negedge clk);
        x = W'(xa); y = W'(ya);
        {zero_x, inv_x, zero_y, inv_y, add_sel, inv_out} = c;
        #2;
        r = model(xa, ya, c);
        check({tag, " vs stated function"}, int'(result), exp & MASK);
        check({tag, " R1 model"}, int'(result), r);
        check({tag, " R7 zero flag"}, int'(is_zero), int'(r == 0));
        check({tag, " R8 neg flag"}, int'(is_neg), (r >> 15) & 1);
    endtask

    task automatic named(int a, int b);
        apply(a, b, 6'b101010, "R9 zero", 0);
        apply(a, b, 6'b111111, "R9 one", 1);
        apply(a, b, 6'b111010, "R9 minus1", -1);
        apply(a, b, 6'b001100, "R9 x", a);
        apply(a, b, 6'b110000, "R9 y", b);
        apply(a, b, 6'b001101, "R9 notx", ~a);
        apply(a, b, 6'b001111, "R9 negx", -a);
        apply(a, b, 6'b011111, "R9 xinc", a + 1);
        apply(a, b, 6'b110010, "R9 ydec", b - 1);
        apply(a, b, 6'b000010, "R9 xplusy", a + b);
        apply(a, b, 6'b010011, "R9 xminusy", a - b);
        apply(a, b, 6'b000111, "R9 yminusx", b - a);
        apply(a, b, 6'b000000, "R9 xandy", a & b);
        apply(a, b, 6'b010101, "R9 xory", a | b);
    endtask

    initial begin
        x = '0; y = '0;
        {zero_x, inv_x, zero_y, inv_y, add_sel, inv_out} = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("reset state result (R5 AND of zeros)", int'(result), 0);
        check("reset state R7 is_zero", int'(is_zero), 1);
        rst_n = 1'b1;
        // R2: zero-then-invert on x; AND with all-ones y exposes it.
        apply(16'h1234, 16'hFFFF, 6'b110000, "R2 zx+nx", 16'hFFFF);
        apply(16'h1234, 16'hFFFF, 6'b100000, "R2 zx only", 0);
        apply(16'h1234, 16'hFFFF, 6'b010000, "R2 nx only", 16'hEDCB);
        // R3: same on y.
        apply(16'hFFFF, 16'h00F0, 6'b001100, "R3 zy+ny", 16'hFFFF);
        apply(16'hFFFF, 16'h00F0, 6'b000100, "R3 ny only", 16'hFF0F);
        // R4: wrap-around.
        apply(16'hFFFF, 16'h0001, 6'b000010, "R4 carry wrap", 0);
        apply(16'h7FFF, 16'h0001, 6'b000010, "R4 sign wrap", 16'h8000);
        // R5: AND.
        apply(16'hF0F0, 16'h3C3C, 6'b000000, "R5 and", 16'h3030);
        // R6: output invert.
        apply(16'hF0F0, 16'h3C3C, 6'b000001, "R6 nand", 16'hCFCF);
        named(0, 0);
        named(16'hFFFF, 16'h8000);
        named(16'h7FFF, 16'h0001);
        for (int i = 0; i < 40; i++) named(int'($urandom_range(0, MASK)), int'($urandom_range(0, MASK)));
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        fork
            wait (done);
            begin
                #(8 * 200000);
                n_cmp++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule